// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands and returns a 32-bit product. Each operand has a sign bit, an 8-bit exponent with an offset of 127, and a 23-bit fraction. The block handles the sign, the exponent and the significand on separate paths. The sign is an XOR. The exponent comes from a signed sum with the offset removed. The significand is a 24×24 product that is normalised and then cut down to 24 bits by dropping the low-order bits.

Results outside the representable range are clamped explicitly. A result that is too large becomes a signed infinity and raises the overflow flag. A result that is too small is encoded with a zero exponent field, either as a denormal or as zero, and raises the underflow flag. The pipeline has two register stages and accepts a new operand pair on every cycle. A strobe marks each operand pair going in and each result coming out. NaN payloads and rounding modes are not modelled.

Top module: `fpmul_sp`

## Requirements
- R1: The sign bit of the result (bit 31) equals the XOR of the sign bits of the two operands, for every result, including clamped ones.
- R2: For in-range results, the exponent field is ea+eb-127, plus 1 when the 48-bit significand product has bit 47 set. The 23-bit fraction is the 23 bits that follow the leading one of the product. The discarded low bits are truncated and never rounded, so 0x3F800001 × 0x3F800001 gives 0x3F800002.
- R3: When the adjusted biased exponent exceeds 254, the result is a signed infinity (bits 30:23 all ones, fraction zero), ovf is 1 and unf is 0.
- R4: When the adjusted biased exponent is below 1, the exponent field is 0 and unf is 1. The fraction is the 24-bit normalised significand shifted right by (1 − adjusted exponent) with the shifted-out bits truncated, or zero once the shift reaches 24. The smallest nonzero output is 0x00000001 (2^-149).
- R5: An operand whose exponent field is 0 (zero or denormal) gives a signed zero result (magnitude bits all 0) with unf = 1 and ovf = 0.
- R6: out_valid is high in exactly the second cycle after each cycle in which in_valid is high. A new pair is accepted every cycle, and results leave in issue order.
- R7: ovf and unf are never both 1, and both are 0 whenever out_valid is 0.
- R8: result keeps its last value in every cycle in which out_valid is 0.
- R9: While rst_n is low, out_valid, ovf, unf and result are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | Result present this cycle |
| result | output | 32 | Product |
| ovf | output | 1 | Result clamped to infinity |
| unf | output | 1 | Result clamped to zero exponent field |

## Verification
Every product, together with its two flags, is due in the second cycle after the cycle that issued it. The driver tags each expected item with that due cycle. The monitor samples just after each rising edge and checks both the value and the arrival cycle, so a result that comes late, early or out of order fails. Cycles without out_valid are checked for low flags and an unchanged result.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
   typedef enum logic [1:0] {
      RNG_NORM  = 2'd0,
      RNG_OVER  = 2'd1,
      RNG_UNDER = 2'd2,
      RNG_ZERO  = 2'd3
   } rng_t;
endpackage

// File: rtl/fpm_front.sv
// Operand split, sign XOR, signed exponent sum and raw significand product.
module fpm_front #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0]        op_a,
   input  logic [EXP_W+FRAC_W:0]        op_b,
   output logic                         sgn,
   output logic signed [EXP_W+1:0]      exp_sum,
   output logic [2*(FRAC_W+1)-1:0]      prod,
   output logic                         zero_op
);
   localparam int W      = 1 + EXP_W + FRAC_W;
   localparam int SIG_W  = FRAC_W + 1;
   localparam int PROD_W = 2 * SIG_W;
   localparam int SUM_W  = EXP_W + 2;
   localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
   localparam logic signed [SUM_W-1:0] BIAS_S = SUM_W'(BIAS);

   logic [EXP_W-1:0] ea, eb;
   logic [SIG_W-1:0] sa, sb;

   always_comb begin
      ea      = op_a[W-2 -: EXP_W];
      eb      = op_b[W-2 -: EXP_W];
      sa      = {1'b1, op_a[FRAC_W-1:0]};
      sb      = {1'b1, op_b[FRAC_W-1:0]};
      sgn     = op_a[W-1] ^ op_b[W-1];
      zero_op = (ea == '0) || (eb == '0);
      exp_sum = $signed({2'b00, ea}) + $signed({2'b00, eb}) - BIAS_S;
      prod    = PROD_W'(sa) * PROD_W'(sb);
   end
endmodule

// File: rtl/fpm_norm.sv
// One-place normalisation of the significand product with truncation.
module fpm_norm #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [2*(FRAC_W+1)-1:0]      prod,
   input  logic signed [EXP_W+1:0]      exp_sum,
   output logic [FRAC_W:0]              sig,
   output logic signed [EXP_W+1:0]      exp_adj
);
   localparam int SIG_W  = FRAC_W + 1;
   localparam int PROD_W = 2 * SIG_W;
   localparam int SUM_W  = EXP_W + 2;

   logic              carry;
   logic [PROD_W-1:0] aligned;
   logic              unused_tail;

   always_comb begin
      carry       = prod[PROD_W-1];
      aligned     = carry ? prod : (prod << 1);
      sig         = aligned[PROD_W-1 -: SIG_W];
      unused_tail = ^aligned[PROD_W-SIG_W-1:0];
      exp_adj     = exp_sum + $signed({{(SUM_W-1){1'b0}}, carry});
   end
endmodule

// File: rtl/fpm_range.sv
// Range classification and final encoding of the product.
module fpm_range
   import fpm_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int FRAC_W    = 23,
   parameter bit DENORM_EN = 1'b1
) (
   input  logic                    sgn,
   input  logic [FRAC_W:0]         sig,
   input  logic signed [EXP_W+1:0] exp_adj,
   input  logic                    zero_op,
   output logic [EXP_W+FRAC_W:0]   res,
   output rng_t                    cls
);
   localparam int SIG_W = FRAC_W + 1;
   localparam int SUM_W = EXP_W + 2;
   localparam int EMAX  = (1 << EXP_W) - 1;
   localparam logic signed [SUM_W-1:0] EXP_TOP = SUM_W'(EMAX - 1);
   localparam logic signed [SUM_W-1:0] EXP_ONE = SUM_W'(1);

   logic [FRAC_W-1:0] den_frac;

   generate
      if (DENORM_EN) begin : g_denorm
         logic [SUM_W-1:0] shamt;
         logic [SIG_W-1:0] den_full;
         logic             unused_msb;
         always_comb begin
            shamt      = SUM_W'(1) - exp_adj;
            den_full   = (shamt >= SUM_W'(SIG_W)) ? '0 : (sig >> shamt);
            den_frac   = den_full[FRAC_W-1:0];
            unused_msb = den_full[SIG_W-1];
         end
      end else begin : g_flush
         logic unused_sig;
         always_comb begin
            den_frac   = '0;
            unused_sig = sig[SIG_W-1];
         end
      end
   endgenerate

   always_comb begin
      if (zero_op) begin
         cls = RNG_ZERO;
         res = {sgn, {(EXP_W+FRAC_W){1'b0}}};
      end else if (exp_adj > EXP_TOP) begin
         cls = RNG_OVER;
         res = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else if (exp_adj < EXP_ONE) begin
         cls = RNG_UNDER;
         res = {sgn, {EXP_W{1'b0}}, den_frac};
      end else begin
         cls = RNG_NORM;
         res = {sgn, exp_adj[EXP_W-1:0], sig[FRAC_W-1:0]};
      end
   end
endmodule

// File: rtl/fpmul_sp.sv
// Two-stage floating-point multiplier.
module fpmul_sp
   import fpm_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int FRAC_W    = 23,
   parameter bit DENORM_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [EXP_W+FRAC_W:0]  op_a,
   input  logic [EXP_W+FRAC_W:0]  op_b,
   output logic                   out_valid,
   output logic [EXP_W+FRAC_W:0]  result,
   output logic                   ovf,
   output logic                   unf
);
   localparam int W      = 1 + EXP_W + FRAC_W;
   localparam int SIG_W  = FRAC_W + 1;
   localparam int PROD_W = 2 * SIG_W;
   localparam int SUM_W  = EXP_W + 2;

   generate
      if (EXP_W < 3 || EXP_W > 15) begin : g_bad_exp
         $error("fpmul_sp: EXP_W out of supported range");
      end
      if (FRAC_W < 2 || FRAC_W > 52) begin : g_bad_frac
         $error("fpmul_sp: FRAC_W out of supported range");
      end
   endgenerate

   // stage 0 (combinational front)
   logic                    f_sgn, f_zero;
   logic signed [SUM_W-1:0] f_sum;
   logic [PROD_W-1:0]       f_prod;

   fpm_front #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_front (
      .op_a    (op_a),
      .op_b    (op_b),
      .sgn     (f_sgn),
      .exp_sum (f_sum),
      .prod    (f_prod),
      .zero_op (f_zero)
   );

   // stage 1 registers
   logic                    s1_v, s1_sgn, s1_zero;
   logic signed [SUM_W-1:0] s1_sum;
   logic [PROD_W-1:0]       s1_prod;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_sgn  <= 1'b0;
         s1_zero <= 1'b0;
         s1_sum  <= '0;
         s1_prod <= '0;
      end else begin
         s1_v <= in_valid;
         if (in_valid) begin
            s1_sgn  <= f_sgn;
            s1_zero <= f_zero;
            s1_sum  <= f_sum;
            s1_prod <= f_prod;
         end
      end
   end

   // stage 1 combinational back end
   logic [SIG_W-1:0]        n_sig;
   logic signed [SUM_W-1:0] n_exp;
   logic [W-1:0]            r_res;
   rng_t                    r_cls;

   fpm_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
      .prod    (s1_prod),
      .exp_sum (s1_sum),
      .sig     (n_sig),
      .exp_adj (n_exp)
   );

   fpm_range #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .DENORM_EN(DENORM_EN)) u_range (
      .sgn     (s1_sgn),
      .sig     (n_sig),
      .exp_adj (n_exp),
      .zero_op (s1_zero),
      .res     (r_res),
      .cls     (r_cls)
   );

   // output registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         ovf       <= 1'b0;
         unf       <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= s1_v;
         ovf       <= s1_v && (r_cls == RNG_OVER);
         unf       <= s1_v && ((r_cls == RNG_UNDER) || (r_cls == RNG_ZERO));
         if (s1_v) result <= r_res;
      end
   end
endmodule

// File: rtl/fpmul_sp_chk.sv
// Property checker, bound to every fpmul_sp instance.
module fpmul_sp_chk #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic [EXP_W+FRAC_W:0] op_a,
   input logic [EXP_W+FRAC_W:0] op_b,
   input logic                  out_valid,
   input logic [EXP_W+FRAC_W:0] result,
   input logic                  ovf,
   input logic                  unf
);
   localparam int W = 1 + EXP_W + FRAC_W;

   a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);

   a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));

   a_r1_sign: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (result[W-1] == $past(op_a[W-1] ^ op_b[W-1], 2)));

   a_r3_inf_code: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> (result[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

   a_r4_zero_exp: assert property (@(posedge clk) disable iff (!rst_n)
      unf |-> (result[W-2 -: EXP_W] == '0));

   a_r7_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !(ovf || unf));

   a_r7_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf && unf));

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(result));
endmodule

bind fpmul_sp fpmul_sp_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_a      (op_a),
   .op_b      (op_b),
   .out_valid (out_valid),
   .result    (result),
   .ovf       (ovf),
   .unf       (unf)
);

// File: tb/fpmul_sp_tb.sv
`timescale 1ns/1ps
module fpmul_sp_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] op_a = '0, op_b = '0;
   logic        out_valid, ovf, unf;
   logic [31:0] result;

   always #2.5 clk = ~clk;

   fpmul_sp u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .op_a(op_a), .op_b(op_b),
      .out_valid(out_valid), .result(result), .ovf(ovf), .unf(unf)
   );

   typedef struct {
      logic [31:0] r;
      bit          o;
      bit          u;
      int          due;
      string       tag;
   } item_t;

   item_t q[$];
   int    total = 0, bad = 0, cyc = 0;
   bit    finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string tag, input bit ok,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // independent model from the requirements (R2..R5)
   function automatic item_t model(input logic [31:0] a, input logic [31:0] b);
      item_t it;
      int ea, eb, e, sh;
      longint p, m;
      bit s;
      s  = a[31] ^ b[31];
      ea = int'(a[30:23]);
      eb = int'(b[30:23]);
      it.o = 0; it.u = 0;
      if (ea == 0 || eb == 0) begin
         it.r = {s, 31'd0}; it.u = 1;
      end else begin
         p = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
         e = ea + eb - 127;
         if (p >= (64'sd1 <<< 47)) begin e = e + 1; m = p >>> 24; end
         else m = p >>> 23;
         if (e >= 255) begin
            it.r = {s, 8'hFF, 23'd0}; it.o = 1;
         end else if (e <= 0) begin
            sh = 1 - e;
            m  = (sh >= 24) ? 64'sd0 : (m >>> sh);
            it.r = {s, 8'h00, m[22:0]}; it.u = 1;
         end else begin
            it.r = {s, e[7:0], m[22:0]};
         end
      end
      return it;
   endfunction

   task automatic push(input logic [31:0] a, input logic [31:0] b, input item_t it);
      @(negedge clk);
      op_a = a; op_b = b; in_valid = 1'b1;
      it.due = cyc + 2;
      q.push_back(it);
   endtask

   task automatic issue(input logic [31:0] a, input logic [31:0] b, input string tag);
      item_t it;
      it = model(a, b);
      it.tag = tag;
      push(a, b, it);
   endtask

   task automatic issue_lit(input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] r, input bit o, input bit u,
                            input string tag);
      item_t it;
      it.r = r; it.o = o; it.u = u; it.tag = tag; it.due = 0;
      push(a, b, it);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         op_a = $urandom; op_b = $urandom;
      end
   endtask

   // monitor / scoreboard
   logic [31:0] last_res = '0;
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n) begin
            if (out_valid) begin
               if (q.size() == 0) begin
                  chk("R6 unexpected out_valid", 1'b0, 64'(result), 64'hX);
               end else begin
                  item_t it;
                  it = q.pop_front();
                  chk(it.tag, {result, ovf, unf} === {it.r, it.o, it.u},
                      64'({result, ovf, unf}), 64'({it.r, it.o, it.u}));
                  chk("R6 due cycle", cyc == it.due, 64'(cyc), 64'(it.due));
               end
            end else begin
               chk("R7 flags low when idle", !(ovf || unf), 64'({ovf, unf}), 64'd0);
               chk("R8 result held", result === last_res, 64'(result), 64'(last_res));
            end
            last_res = result;
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #100_000;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R9 reset outputs", {out_valid, ovf, unf, result} === 35'd0,
          64'({out_valid, ovf, unf, result}), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R2 normal products, back to back (R6 throughput)
      issue_lit(32'h3F800000, 32'h3F800000, 32'h3F800000, 0, 0, "R2 one*one");
      issue_lit(32'h3FC00000, 32'h3FC00000, 32'h40100000, 0, 0, "R2 carry 1.5*1.5");
      issue_lit(32'h40000000, 32'h40400000, 32'h40C00000, 0, 0, "R2 2*3");
      issue_lit(32'hC0000000, 32'h40400000, 32'hC0C00000, 0, 0, "R1 neg sign");
      issue_lit(32'h3F800001, 32'h3F800001, 32'h3F800002, 0, 0, "R2 truncation");
      issue_lit(32'h7F000000, 32'h3F800000, 32'h7F000000, 0, 0, "R3 max exp no clamp");
      idle(3);
      // R3 overflow
      issue_lit(32'h7F000000, 32'h40000000, 32'h7F800000, 1, 0, "R3 overflow pos");
      issue_lit(32'hFF000000, 32'h40000000, 32'hFF800000, 1, 0, "R3 overflow neg");
      idle(1);
      // R4 underflow
      issue_lit(32'h00800000, 32'h3F000000, 32'h00400000, 0, 1, "R4 denormal half");
      issue_lit(32'h00800000, 32'h34000000, 32'h00000001, 0, 1, "R4 smallest 2^-149");
      issue_lit(32'h80800000, 32'h33800000, 32'h80000000, 0, 1, "R4 shift 24 to zero");
      issue_lit(32'h00800000, 32'h00800000, 32'h00000000, 0, 1, "R4 deep underflow");
      idle(2);
      // R5 zero exponent operands
      issue_lit(32'h00000000, 32'h3F800000, 32'h00000000, 0, 1, "R5 zero operand");
      issue_lit(32'h80000000, 32'h3F800000, 32'h80000000, 0, 1, "R5 signed zero");
      issue_lit(32'h3F800000, 32'h00000001, 32'h00000000, 0, 1, "R5 denormal operand");
      idle(4);
      // mixed stream against the model, with gaps
      for (int i = 0; i < 300; i++) begin
         logic [31:0] a, b;
         a = $urandom; b = $urandom;
         if (i % 3 != 0) begin
            a[30:23] = 8'(64 + ($urandom % 128));
            b[30:23] = 8'(64 + ($urandom % 128));
         end
         issue(a, b, "R2 R3 R4 R1 random");
         if (i % 7 == 0) idle(1 + (i % 3));
      end
      idle(6);
      chk("R6 queue drained", q.size() == 0, 64'(q.size()), 64'd0);
      finish_run();
   end
endmodule